// File: doc/BRIEF.md
# Three-Phase Gate Drive Protection Logic

This block is the digital guard between a motor-control PWM generator and the six gate drivers of a three-phase half-bridge inverter. Each phase carries one active-high high-side command and one active-high low-side command. The block passes these commands to registered gate outputs. It blocks any phase whose two commands overlap. It also shuts the whole bridge down on over-current or a logic-supply undervoltage, and it removes a single high-side gate when that phase's bootstrap supply is too low.

All inputs are already synchronized digital flags. The over-current input comes from a comparator and must stay high for a programmable blanking window before it is believed. A detection latches a shutdown, and the fault output then stays high for a programmable hold time. After an undervoltage, and after reset, each phase keeps its high side locked until its own low-side command has been seen. This ensures the bootstrap capacitor has had a chance to charge. Every output is registered, so the gate and fault outputs reflect the inputs sampled at the preceding rising clock edge.

Top module: `gate_drive_guard`

## Requirements
- R1: While reset is asserted and after it is released, all six gate outputs are low, the fault output is low, and every phase waits for a low-side command before its high side can turn on.
- R2: With enable high and no fault, a phase with only its low command high drives only its low gate, and a phase with neither command high drives both gates low. Outputs appear one clock after the inputs are sampled.
- R3: A phase whose high and low commands are both high drives both of its gates low. The other phases are unaffected.
- R4: With enable low, all gates and the fault output are low whatever the other inputs are. Enable low also discards any running over-current hold and any partial blanking count.
- R5: The over-current input causes no effect unless it is sampled high on BLANK_CYC consecutive rising edges. A shorter burst leaves the gates and fault untouched, and a gap restarts the count.
- R6: On the edge that samples the BLANK_CYC-th consecutive over-current high, all gates go low and the fault output rises. If over-current is then gone, the fault stays high for exactly HOLD_CYC cycles, and the gates follow the commands again when it falls.
- R7: If over-current is still high when the hold time ends, the fault stays high and the gates stay low until the over-current input is sampled low. Both recover on that same edge.
- R8: A new qualified over-current detection during the hold time restarts the hold time from its full length.
- R9: With enable high, a VDD undervoltage flag forces all gates low and the fault output high. The fault clears on the first edge that samples the flag low.
- R10: A phase's high gate stays low, even for a lone high command, until that phase's low command has been sampled high at a time with no VDD undervoltage. A VDD undervoltage returns every phase to this waiting state.
- R11: A bootstrap undervoltage flag (bit i for phase i) turns off only that phase's high gate, leaves the fault output low, and the gate resumes once the flag drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Driver enable, active high |
| oc_i | input | 1 | Over-current comparator flag |
| vdd_uv_i | input | 1 | Logic supply undervoltage flag |
| bs_uv_i | input | 3 | Per-phase bootstrap undervoltage flags |
| hi_cmd_i | input | 3 | High-side commands, bit i is phase i |
| lo_cmd_i | input | 3 | Low-side commands, bit i is phase i |
| hi_gate_o | output | 3 | High-side gate outputs |
| lo_gate_o | output | 3 | Low-side gate outputs |
| fault_o | output | 1 | Fault indication, active high |

## Verification
The command path is exercised with lone high, lone low, idle and overlapping commands on mixed phases in one cycle. This shows that cross-conduction blocking is confined to the offending phase. Over-current is driven as a burst one cycle short of the blanking window, as an exact window followed by release, as a second window inside the hold time, and as a level that outlasts the hold time. These four patterns separate blanking, hold length, timer restart and wait-for-release. Enable is dropped with over-current present, and VDD and bootstrap undervoltage are each raised alone. This separates the fault-silent shutdown from the fault-raising one and confirms the per-phase high-side lock after undervoltage.

// File: rtl/gdp_pkg.sv
package gdp_pkg;

    localparam int unsigned NUM_PH = 3;

    typedef enum logic [1:0] {
        TRIP_IDLE = 2'd0,
        TRIP_HOLD = 2'd1,
        TRIP_WAIT = 2'd2
    } trip_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Gate pair for one phase: overlap kills both, high side needs permission
    function automatic leg_t leg_resolve(input leg_t cmd, input logic run, input logic hi_ok);
        leg_t r;
        r.hi = run & hi_ok & cmd.hi & ~cmd.lo;
        r.lo = run & cmd.lo & ~cmd.hi;
        return r;
    endfunction

endpackage

// File: rtl/gdp_oc_blank.sv
module gdp_oc_blank
    import gdp_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 35
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic oc_i,
    output logic detect_o
);
    localparam int unsigned CW = cnt_w(BLANK_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);
    localparam logic [CW-1:0] SAT  = CW'(BLANK_CYC);

    logic [CW-1:0] cnt_q;

    // Counts consecutive high samples; saturates so one episode fires once
    always_ff @(posedge clk) begin
        if (rst || clr_i || !oc_i) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign detect_o = oc_i & ~clr_i & (cnt_q == LAST);

endmodule

// File: rtl/gdp_trip_timer.sv
module gdp_trip_timer
    import gdp_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic detect_i,
    input  logic oc_i,
    output logic trip_o
);
    localparam int unsigned TW = cnt_w(HOLD_CYC);
    localparam logic [TW-1:0] LOAD = TW'(HOLD_CYC - 1);

    trip_state_e   state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        if (clr_i) begin
            state_d = TRIP_IDLE;
            tmr_d   = '0;
        end else if (detect_i) begin
            state_d = TRIP_HOLD;
            tmr_d   = LOAD;
        end else begin
            unique case (state_q)
                TRIP_HOLD: begin
                    if (tmr_q == '0) begin
                        state_d = oc_i ? TRIP_WAIT : TRIP_IDLE;
                    end else begin
                        tmr_d = tmr_q - TW'(1);
                    end
                end
                TRIP_WAIT: begin
                    if (!oc_i) state_d = TRIP_IDLE;
                end
                default: state_d = TRIP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRIP_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    assign trip_o = (state_d != TRIP_IDLE);

endmodule

// File: rtl/gdp_leg.sv
module gdp_leg
    import gdp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  leg_t cmd_i,
    input  logic run_i,
    input  logic vdd_uv_i,
    input  logic bs_uv_i,
    output leg_t gate_o
);
    logic armed_q;
    leg_t gate_q;

    // High side unlocks only after a low-side command with VDD healthy
    always_ff @(posedge clk) begin
        if (rst || vdd_uv_i) begin
            armed_q <= 1'b0;
        end else if (cmd_i.lo) begin
            armed_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
        end else begin
            gate_q <= leg_resolve(cmd_i, run_i, armed_q & ~bs_uv_i);
        end
    end

    assign gate_o = gate_q;

endmodule

// File: rtl/gate_drive_guard.sv
module gate_drive_guard
    import gdp_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 35,
    parameter int unsigned HOLD_CYC  = 200000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              oc_i,
    input  logic              vdd_uv_i,
    input  logic [NUM_PH-1:0] bs_uv_i,
    input  logic [NUM_PH-1:0] hi_cmd_i,
    input  logic [NUM_PH-1:0] lo_cmd_i,
    output logic [NUM_PH-1:0] hi_gate_o,
    output logic [NUM_PH-1:0] lo_gate_o,
    output logic              fault_o
);
    logic clr;
    logic oc_det;
    logic trip;
    logic run;
    logic fault_q;

    assign clr = ~enable_i;

    gdp_oc_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr),
        .oc_i     (oc_i),
        .detect_o (oc_det)
    );

    gdp_trip_timer #(.HOLD_CYC(HOLD_CYC)) u_trip (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr),
        .detect_i (oc_det),
        .oc_i     (oc_i),
        .trip_o   (trip)
    );

    assign run = enable_i & ~vdd_uv_i & ~trip;

    for (genvar g = 0; g < NUM_PH; g++) begin : g_leg
        leg_t cmd;
        leg_t gate;
        assign cmd.hi = hi_cmd_i[g];
        assign cmd.lo = lo_cmd_i[g];

        gdp_leg u_leg (
            .clk      (clk),
            .rst      (rst),
            .cmd_i    (cmd),
            .run_i    (run),
            .vdd_uv_i (vdd_uv_i),
            .bs_uv_i  (bs_uv_i[g]),
            .gate_o   (gate)
        );

        assign hi_gate_o[g] = gate.hi;
        assign lo_gate_o[g] = gate.lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= enable_i & (vdd_uv_i | trip);
        end
    end

    assign fault_o = fault_q;

endmodule

// File: rtl/gdp_guard_checker.sv
module gdp_guard_checker
    import gdp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              enable_i,
    input logic              oc_i,
    input logic              vdd_uv_i,
    input logic [NUM_PH-1:0] bs_uv_i,
    input logic [NUM_PH-1:0] hi_cmd_i,
    input logic [NUM_PH-1:0] lo_cmd_i,
    input logic [NUM_PH-1:0] hi_gate_o,
    input logic [NUM_PH-1:0] lo_gate_o,
    input logic              fault_o
);
    assert_xcond_off_R3: assert property (@(posedge clk) disable iff (rst)
        (|(hi_cmd_i & lo_cmd_i)) |=>
            (((hi_gate_o | lo_gate_o) & $past(hi_cmd_i & lo_cmd_i)) == '0));

    assert_enable_low_R4: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (hi_gate_o == '0 && lo_gate_o == '0 && !fault_o));

    assert_short_oc_R5: assert property (@(posedge clk) disable iff (rst)
        (!oc_i && !vdd_uv_i) |=> !$rose(fault_o));

    assert_fault_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (hi_gate_o == '0 && lo_gate_o == '0));

    assert_vdd_uv_R9: assert property (@(posedge clk) disable iff (rst)
        (enable_i && vdd_uv_i) |=> (fault_o && hi_gate_o == '0 && lo_gate_o == '0));

    assert_bs_uv_R11: assert property (@(posedge clk) disable iff (rst)
        (|bs_uv_i) |=> ((hi_gate_o & $past(bs_uv_i)) == '0));

endmodule

bind gate_drive_guard gdp_guard_checker u_guard_chk (
    .clk       (clk),
    .rst       (rst),
    .enable_i  (enable_i),
    .oc_i      (oc_i),
    .vdd_uv_i  (vdd_uv_i),
    .bs_uv_i   (bs_uv_i),
    .hi_cmd_i  (hi_cmd_i),
    .lo_cmd_i  (lo_cmd_i),
    .hi_gate_o (hi_gate_o),
    .lo_gate_o (lo_gate_o),
    .fault_o   (fault_o)
);

// File: tb/gate_drive_guard_test.sv
module gate_drive_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam int BLANK = 4;
    localparam int HOLD  = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, oc = 1'b0, uv = 1'b0;
    logic [2:0] bs = '0, hi = '0, lo = '0;
    logic [2:0] hi_g, lo_g;
    logic       flt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0] ehi;
        logic [2:0] elo;
        logic       ef;
        bit         chk;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_drive_guard #(.BLANK_CYC(BLANK), .HOLD_CYC(HOLD)) uut (
        .clk       (clk),
        .rst       (rst),
        .enable_i  (en),
        .oc_i      (oc),
        .vdd_uv_i  (uv),
        .bs_uv_i   (bs),
        .hi_cmd_i  (hi),
        .lo_cmd_i  (lo),
        .hi_gate_o (hi_g),
        .lo_gate_o (lo_g),
        .fault_o   (flt)
    );

    task automatic compare(input exp_t it);
        n_chk++;
        if (hi_g !== it.ehi || lo_g !== it.elo || flt !== it.ef) begin
            n_bad++;
            $display("FAIL %s: got hi=%b lo=%b f=%b expected hi=%b lo=%b f=%b",
                     it.req, hi_g, lo_g, flt, it.ehi, it.elo, it.ef);
        end
    endtask

    // Driver: apply one cycle of stimulus, queue the expected registered result
    task automatic drive(input logic e, input logic o, input logic u, input logic [2:0] b,
                         input logic [2:0] h, input logic [2:0] l,
                         input logic [2:0] ehi, input logic [2:0] elo, input logic ef,
                         input string req);
        exp_t it;
        @(negedge clk);
        en = e; oc = o; uv = u; bs = b; hi = h; lo = l;
        it.ehi = ehi; it.elo = elo; it.ef = ef; it.chk = 1'b1; it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: pop one item after each active edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (sb.size() > 0) compare(sb.pop_front());
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t rs;
        repeat (3) @(negedge clk);
        rs.ehi = '0; rs.elo = '0; rs.ef = 1'b0; rs.chk = 1'b1; rs.req = "R1";
        compare(rs);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R10: high side locked right after reset
        drive(1,0,0,3'b000,3'b001,3'b000, 3'b000,3'b000,0, "R1");
        drive(1,0,0,3'b000,3'b001,3'b000, 3'b000,3'b000,0, "R10");
        // R2: lone low, then lone high after arming, then idle
        drive(1,0,0,3'b000,3'b000,3'b001, 3'b000,3'b001,0, "R2");
        drive(1,0,0,3'b000,3'b001,3'b000, 3'b001,3'b000,0, "R2");
        drive(1,0,0,3'b000,3'b000,3'b000, 3'b000,3'b000,0, "R2");
        drive(1,0,0,3'b000,3'b000,3'b111, 3'b000,3'b111,0, "R2");
        drive(1,0,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R10");
        // R3: overlap on phase 1 only, then on all phases
        drive(1,0,0,3'b000,3'b011,3'b110, 3'b001,3'b100,0, "R3");
        drive(1,0,0,3'b000,3'b111,3'b111, 3'b000,3'b000,0, "R3");
        // R11: bootstrap undervoltage on phase 1
        drive(1,0,0,3'b010,3'b111,3'b000, 3'b101,3'b000,0, "R11");
        drive(1,0,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R11");

        // R5: bursts one short of blanking, separated by a gap
        for (int k = 0; k < BLANK-1; k++)
            drive(1,1,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R5");
        drive(1,0,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R5");
        for (int k = 0; k < BLANK-1; k++)
            drive(1,1,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R5");
        drive(1,0,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R5");

        // R6: exact window, then hold length
        for (int k = 0; k < BLANK-1; k++)
            drive(1,1,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R6");
        drive(1,1,0,3'b000,3'b111,3'b000, 3'b000,3'b000,1, "R6");
        for (int j = 1; j < HOLD; j++)
            drive(1,0,0,3'b000,3'b111,3'b000, 3'b000,3'b000,1, "R6");
        drive(1,0,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R6");

        // R8: renewed detection restarts the hold
        for (int k = 0; k < BLANK-1; k++)
            drive(1,1,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R8");
        drive(1,1,0,3'b000,3'b111,3'b000, 3'b000,3'b000,1, "R8");
        for (int j = 1; j < 10; j++)
            drive(1,0,0,3'b000,3'b111,3'b000, 3'b000,3'b000,1, "R8");
        for (int j = 10; j < 10 + BLANK; j++)
            drive(1,1,0,3'b000,3'b111,3'b000, 3'b000,3'b000,1, "R8");
        for (int j = 10 + BLANK; j < 10 + BLANK - 1 + HOLD; j++)
            drive(1,0,0,3'b000,3'b111,3'b000, 3'b000,3'b000,1, "R8");
        drive(1,0,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R8");

        // R7: over-current outlasts the hold
        for (int k = 0; k < BLANK-1; k++)
            drive(1,1,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R7");
        drive(1,1,0,3'b000,3'b111,3'b000, 3'b000,3'b000,1, "R7");
        for (int j = 1; j <= HOLD + 5; j++)
            drive(1,1,0,3'b000,3'b111,3'b000, 3'b000,3'b000,1, "R7");
        drive(1,0,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R7");

        // R4: enable low with over-current present, then count restarts
        for (int k = 0; k < 6; k++)
            drive(0,1,0,3'b000,3'b111,3'b000, 3'b000,3'b000,0, "R4");
        for (int k = 0; k < BLANK-1; k++)
            drive(1,1,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R4");
        drive(1,1,0,3'b000,3'b111,3'b000, 3'b000,3'b000,1, "R4");
        drive(0,0,0,3'b000,3'b111,3'b000, 3'b000,3'b000,0, "R4");
        drive(1,0,0,3'b000,3'b111,3'b000, 3'b111,3'b000,0, "R4");

        // R9 / R10: VDD undervoltage, then per-phase relock
        for (int k = 0; k < 3; k++)
            drive(1,0,1,3'b000,3'b111,3'b000, 3'b000,3'b000,1, "R9");
        drive(1,0,0,3'b000,3'b111,3'b000, 3'b000,3'b000,0, "R9");
        drive(1,0,0,3'b000,3'b111,3'b000, 3'b000,3'b000,0, "R10");
        drive(1,0,0,3'b000,3'b000,3'b010, 3'b000,3'b010,0, "R10");
        drive(1,0,0,3'b000,3'b111,3'b000, 3'b010,3'b000,0, "R10");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule